// File: doc/BRIEF.md
# Delay-Line Voltage Quantizer Back-End

This block is the digital side of a time-based voltage quantizer that runs once per switching period. At the start of each period it launches a test pulse into an external chain of delay cells whose propagation speed rises with the sensed supply voltage. At a fixed fraction of the period it captures the tap outputs into flip-flops. It then turns the captured word into a small signed error code and holds the chain in reset for the rest of the period, so every conversion starts from a cleared line.

A calibration mode splits the period into two halves. The first half converts a trusted reference voltage, selected through `sel_ref_o`, and keeps that result. The second half converts the sensed input. The reported error is the stored reference result minus the input result, which cancels process and temperature drift in the delay cells. The reference pass can be repeated only every `CAL_EVERY` calibrated periods. Between refreshes the stored reference result is reused.

Top module: `dlq_backend`

## Requirements
- R1: In a normal-mode period of `PERIOD` clock cycles (cycle index 0 to `PERIOD-1`), `test_o` is high exactly in cycles 0 to `S-1`, where `S = PERIOD*SAMP_NUM/SAMP_DEN` (24 for 32 cycles at 6/8).
- R2: `sample_o` is high for the single cycle `S` of a conversion, and `taps_i` is captured at the clock edge that ends that cycle.
- R3: `line_rst_o` is high in every cycle after the sample cycle up to the end of the conversion window. While `rst_n` is low, `line_rst_o` is high, `test_o`, `sample_o`, `sel_ref_o` and `err_valid_o` are low, and `err_o` is 0. At most one of `test_o`, `sample_o` and `line_rst_o` is high in any cycle.
- R4: A normal-mode error is the number of ones in the captured word minus `TAPS/2`. For eight taps, `taps_i[0]` is the first tap, 8'b00001111 gives 0, all zeros gives -4 and all ones gives +4. `err_o` is two's complement.
- R5: Words that are not thermometer codes (bubbles) are encoded by their count of ones alone. Bit positions have no effect.
- R6: `err_valid_o` is a one-cycle pulse in cycle `S+2` of a normal-mode period (`H+SH+2` in calibration mode). `err_o` holds its value until the next pulse.
- R7: In calibration mode each half of `H = PERIOD/2` cycles runs a conversion with the sample at local cycle `SH = H*SAMP_NUM/SAMP_DEN`. `sel_ref_o` is high throughout a first half that converts the reference and low in the second half.
- R8: A calibrated error equals the stored reference code minus the input code of the same period. Both codes are formed as in R4, and the result lies in the range -`TAPS` to +`TAPS`.
- R9: Counting calibration-mode periods from 0 at mode entry, the reference is converted only in periods whose index is a multiple of `CAL_EVERY`. In the other periods the first half keeps `test_o`, `sample_o` and `sel_ref_o` low and `line_rst_o` high, and the previous reference code is reused. The stored code is 0 after reset.
- R10: `cal_mode_i` is sampled only at the period boundary. A change in the middle of a period does not alter that period's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, `PERIOD` cycles per switching period |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_mode_i | input | 1 | Requests calibration mode from the next period |
| taps_i | input | TAPS | Delay-line tap outputs, bit 0 nearest the launch point |
| test_o | output | 1 | Test pulse into the delay line |
| sample_o | output | 1 | Tap capture strobe |
| line_rst_o | output | 1 | Clears all delay cells |
| sel_ref_o | output | 1 | Selects the reference voltage as delay-line supply |
| err_o | output | $clog2(TAPS+1)+2 | Signed error code |
| err_valid_o | output | 1 | One-cycle pulse marking a new `err_o` |

## Verification
All 256 tap words are driven in normal mode, including every bubbled pattern. A design that searched for the first zero instead of counting ones would report wrong codes for those words. A design that was off by one in the offset would miss the 0, -4 and +4 end points. In calibration mode, every pairing of reference count and input count is driven with rotated bit patterns and a refresh interval of three. A swapped subtraction, a reference register that reloads in skipped periods, or a divider that does not restart at mode entry would each give wrong differences. The phase outputs are compared cycle by cycle around a mid-period mode request, which catches a design that latches the mode immediately.

// File: rtl/dlq_pkg.sv
package dlq_pkg;

   typedef enum logic [1:0] {
      DLQ_LAUNCH = 2'd0,
      DLQ_SAMPLE = 2'd1,
      DLQ_CLEAR  = 2'd2
   } dlq_phase_e;

   function automatic int dlq_scale(input int span, input int num, input int den);
      return (span * num) / den;
   endfunction

   function automatic dlq_phase_e dlq_phase_of(input int loc, input int sample_at);
      if (loc < sample_at)       return DLQ_LAUNCH;
      else if (loc == sample_at) return DLQ_SAMPLE;
      else                       return DLQ_CLEAR;
   endfunction

endpackage

// File: rtl/dlq_period_seq.sv
module dlq_period_seq #(
   parameter int PERIOD    = 32,
   parameter int SAMP_NUM  = 6,
   parameter int SAMP_DEN  = 8,
   parameter int CAL_EVERY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_mode_i,
   output logic test_o,
   output logic sample_o,
   output logic line_rst_o,
   output logic sel_ref_o,
   output logic cal_period_o
);
   import dlq_pkg::*;

   localparam int HALF   = PERIOD / 2;
   localparam int S_FULL = dlq_scale(PERIOD, SAMP_NUM, SAMP_DEN);
   localparam int S_HALF = dlq_scale(HALF, SAMP_NUM, SAMP_DEN);
   localparam int CNTW   = $clog2(PERIOD);

   if (PERIOD < 8 || PERIOD % 2 != 0) begin : g_bad_period
      $error("dlq_period_seq: PERIOD must be even and at least 8");
   end
   if (S_FULL < 1 || S_FULL + 2 >= PERIOD) begin : g_bad_full
      $error("dlq_period_seq: full-period sample point leaves no room");
   end
   if (S_HALF < 1 || S_HALF + 2 >= HALF) begin : g_bad_half
      $error("dlq_period_seq: half-period sample point leaves no room");
   end
   if (CAL_EVERY < 1) begin : g_bad_every
      $error("dlq_period_seq: CAL_EVERY must be at least 1");
   end

   logic [CNTW-1:0] cnt_q;
   logic            last_cyc;
   logic            mode_q;
   logic            cal_now;

   assign last_cyc = (cnt_q == CNTW'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mode_q <= 1'b0;
      end else begin
         cnt_q <= last_cyc ? '0 : cnt_q + 1'b1;
         if (last_cyc) mode_q <= cal_mode_i;
      end
   end

   if (CAL_EVERY == 1) begin : g_every
      assign cal_now = mode_q;
   end else begin : g_div
      localparam int DIVW = $clog2(CAL_EVERY);
      logic [DIVW-1:0] div_q;
      logic            now_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= '0;
            now_q <= 1'b0;
         end else if (last_cyc) begin
            now_q <= cal_mode_i && (div_q == '0);
            if (!cal_mode_i)                          div_q <= '0;
            else if (div_q == DIVW'(CAL_EVERY - 1))   div_q <= '0;
            else                                      div_q <= div_q + 1'b1;
         end
      end
      assign cal_now = now_q;
   end

   logic [CNTW-1:0] loc;
   dlq_phase_e      ph;
   logic            act;
   logic            sref;

   always_comb begin
      loc  = cnt_q;
      ph   = dlq_phase_of(int'(cnt_q), S_FULL);
      act  = 1'b1;
      sref = 1'b0;
      if (mode_q) begin
         if (cnt_q < CNTW'(HALF)) begin
            ph   = dlq_phase_of(int'(cnt_q), S_HALF);
            act  = cal_now;
            sref = cal_now;
         end else begin
            loc = cnt_q - CNTW'(HALF);
            ph  = dlq_phase_of(int'(loc), S_HALF);
         end
      end
   end

   assign test_o       = rst_n & act & (ph == DLQ_LAUNCH);
   assign sample_o     = rst_n & act & (ph == DLQ_SAMPLE);
   assign line_rst_o   = ~rst_n | ~act | (ph == DLQ_CLEAR);
   assign sel_ref_o    = rst_n & sref;
   assign cal_period_o = mode_q;

   AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({test_o, sample_o, line_rst_o})); // R3
   AST_SAMPLE_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |-> $past(test_o)); // R2
   AST_REF_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_ref_o) |-> $past(line_rst_o)); // R7

endmodule

// File: rtl/dlq_tap_encoder.sv
module dlq_tap_encoder #(
   parameter int TAPS = 8,
   parameter int CW   = $clog2(TAPS + 1) + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TAPS-1:0]      taps_i,
   input  logic                 sample_i,
   input  logic                 sel_ref_i,
   output logic signed [CW-1:0] code_o,
   output logic                 done_o,
   output logic                 done_ref_o
);
   localparam int NW = $clog2(TAPS + 1);

   if (CW != NW + 1) begin : g_bad_cw
      $error("dlq_tap_encoder: CW must be one bit wider than the ones count");
   end

   logic [TAPS-1:0] cap_q;
   logic            done_q;
   logic            done_ref_q;
   logic [NW-1:0]   ones;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q      <= '0;
         done_q     <= 1'b0;
         done_ref_q <= 1'b0;
      end else begin
         if (sample_i) cap_q <= taps_i;
         done_q     <= sample_i;
         done_ref_q <= sample_i & sel_ref_i;
      end
   end

   always_comb begin
      ones = '0;
      for (int k = 0; k < TAPS; k++) begin
         ones = ones + NW'(cap_q[k]);
      end
   end

   assign code_o     = $signed({1'b0, ones}) - $signed(CW'(TAPS / 2));
   assign done_o     = done_q;
   assign done_ref_o = done_ref_q;

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (code_o >= -(TAPS / 2) && code_o <= (TAPS / 2))); // R4
   AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(sample_i)); // R2

endmodule

// File: rtl/dlq_cal_combine.sv
module dlq_cal_combine #(
   parameter int TAPS = 8,
   parameter int CW   = $clog2(TAPS + 1) + 1,
   parameter int OW   = CW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [CW-1:0] code_i,
   input  logic                 done_i,
   input  logic                 done_ref_i,
   input  logic                 cal_i,
   output logic signed [OW-1:0] err_o,
   output logic                 err_valid_o
);
   if (OW != CW + 1) begin : g_bad_ow
      $error("dlq_cal_combine: OW must be one bit wider than CW");
   end

   logic signed [CW-1:0] ref_q;
   logic signed [OW-1:0] err_q;
   logic                 vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= '0;
         err_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= done_i & ~done_ref_i;
         if (done_i & done_ref_i) ref_q <= code_i;
         if (done_i & ~done_ref_i) begin
            err_q <= cal_i ? (OW'(ref_q) - OW'(code_i)) : OW'(code_i);
         end
      end
   end

   assign err_o       = err_q;
   assign err_valid_o = vld_q;

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid_o |=> !err_valid_o); // R6
   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_i && done_ref_i) |=> $stable(ref_q)); // R9
   AST_CAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid_o |-> (err_o >= -TAPS && err_o <= TAPS)); // R8

endmodule

// File: rtl/dlq_backend.sv
module dlq_backend #(
   parameter int TAPS      = 8,
   parameter int PERIOD    = 32,
   parameter int SAMP_NUM  = 6,
   parameter int SAMP_DEN  = 8,
   parameter int CAL_EVERY = 1,
   localparam int CW       = $clog2(TAPS + 1) + 1,
   localparam int OW       = CW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cal_mode_i,
   input  logic [TAPS-1:0]      taps_i,
   output logic                 test_o,
   output logic                 sample_o,
   output logic                 line_rst_o,
   output logic                 sel_ref_o,
   output logic signed [OW-1:0] err_o,
   output logic                 err_valid_o
);
   if (TAPS < 2 || TAPS % 2 != 0) begin : g_bad_taps
      $error("dlq_backend: TAPS must be even and at least 2");
   end

   logic                 cal_period;
   logic signed [CW-1:0] code;
   logic                 done;
   logic                 done_ref;

   dlq_period_seq #(
      .PERIOD    (PERIOD),
      .SAMP_NUM  (SAMP_NUM),
      .SAMP_DEN  (SAMP_DEN),
      .CAL_EVERY (CAL_EVERY)
   ) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cal_mode_i   (cal_mode_i),
      .test_o       (test_o),
      .sample_o     (sample_o),
      .line_rst_o   (line_rst_o),
      .sel_ref_o    (sel_ref_o),
      .cal_period_o (cal_period)
   );

   dlq_tap_encoder #(
      .TAPS (TAPS),
      .CW   (CW)
   ) enc_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .taps_i     (taps_i),
      .sample_i   (sample_o),
      .sel_ref_i  (sel_ref_o),
      .code_o     (code),
      .done_o     (done),
      .done_ref_o (done_ref)
   );

   dlq_cal_combine #(
      .TAPS (TAPS),
      .CW   (CW),
      .OW   (OW)
   ) comb_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_i      (code),
      .done_i      (done),
      .done_ref_i  (done_ref),
      .cal_i       (cal_period),
      .err_o       (err_o),
      .err_valid_o (err_valid_o)
   );

   AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid_o |-> $past(sample_o && !sel_ref_o, 2)); // R6

endmodule

// File: tb/dlq_backend_tb_top.sv
module dlq_backend_tb_top;
   localparam int P   = 32;
   localparam int CE  = 3;
   localparam int NT  = 8;
   localparam int S   = P * 6 / 8;
   localparam int H   = P / 2;
   localparam int SH  = H * 6 / 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cal_mode;
   logic [NT-1:0]     taps;
   logic              test_o, sample_o, line_rst_o, sel_ref_o, err_valid_o;
   logic signed [5:0] err_o;
   logic [NT-1:0]     ref_w, in_w;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   assign taps = sel_ref_o ? ref_w : in_w;

   dlq_backend #(.TAPS(NT), .PERIOD(P), .SAMP_NUM(6), .SAMP_DEN(8), .CAL_EVERY(CE)) dut_i (
      .clk(clk), .rst_n(rst_n), .cal_mode_i(cal_mode), .taps_i(taps),
      .test_o(test_o), .sample_o(sample_o), .line_rst_o(line_rst_o),
      .sel_ref_o(sel_ref_o), .err_o(err_o), .err_valid_o(err_valid_o));

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [3:0] exp_ctl(input int ph, input bit cal, input bit calnow);
      int loc, sp;
      bit sel;
      if (!cal) begin
         loc = ph; sp = S; sel = 1'b0;
      end else if (ph < H) begin
         if (!calnow) return 4'b0010;
         loc = ph; sp = SH; sel = 1'b1;
      end else begin
         loc = ph - H; sp = SH; sel = 1'b0;
      end
      return {loc < sp, loc == sp, loc > sp, sel};
   endfunction

   function automatic logic [NT-1:0] mk(input int n, input int rot);
      logic [2*NT-1:0] x;
      x = (2*NT)'((1 << n) - 1);
      x = x << (rot % NT);
      return x[NT-1:0] | x[2*NT-1:NT];
   endfunction

   task automatic wait_valid(input int exp_ph, output bit got);
      int t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!err_valid_o && t < 3 * P);
      got = err_valid_o;
      if (!got) begin
         chk(1'b0, "R6 valid timeout", 0, 1);
      end else begin
         chk((cyc % P) == exp_ph, "R6 valid cycle", cyc % P, exp_ph);
      end
   endtask

   task automatic check_hold(input int held);
      @(negedge clk);
      chk(!err_valid_o && (int'(err_o) == held), "R6 pulse and hold",
          int'(err_o) + (err_valid_o ? 100 : 0), held);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int refm;
      int jcal;
      bit got;
      rst_n    = 1'b0;
      cal_mode = 1'b0;
      ref_w    = '0;
      in_w     = '0;
      repeat (4) @(negedge clk);
      #1;
      chk({test_o, sample_o, line_rst_o, sel_ref_o, err_valid_o} == 5'b00100,
          "R3 reset outputs", {test_o, sample_o, line_rst_o, sel_ref_o, err_valid_o}, 5'b00100);
      chk(err_o == 0, "R3 reset error value", int'(err_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // phase timing: periods 0,1 normal (mode request mid period 1), 2..4 calibrated
      for (int k = 0; k < 5 * P; k++) begin
         int pi;
         bit cal, calnow;
         logic [3:0] act, exp;
         if (k > 0) @(negedge clk);
         #1;
         pi     = k / P;
         cal    = (pi >= 2);
         calnow = cal && (((pi - 2) % CE) == 0);
         exp    = exp_ctl(cyc % P, cal, calnow);
         act    = {test_o, sample_o, line_rst_o, sel_ref_o};
         if (pi < 2)       chk(act == exp, (pi == 1) ? "R10 R1 R2 R3 normal phases" : "R1 R2 R3 normal phases", act, exp);
         else if (calnow)  chk(act == exp, "R7 calibrating phases", act, exp);
         else              chk(act == exp, "R9 skipped reference half", act, exp);
         if (k == P + 5) cal_mode = 1'b1;
      end
      refm = -4; // reference word was all zeros in period 2
      cal_mode = 1'b0;

      // all 256 words in normal mode
      for (int w = 0; w < 256; w++) begin
         int n, e;
         in_w = NT'(w);
         wait_valid(S + 2, got);
         if (got) begin
            n = $countones(NT'(w));
            e = n - NT / 2;
            chk(int'(err_o) == e, (NT'(w) == NT'((1 << n) - 1)) ? "R4 thermometer code" : "R5 bubbled code",
                int'(err_o), e);
            check_hold(e);
         end
      end

      // calibrated sweep, reference refreshed every CE periods
      cal_mode = 1'b1;
      jcal     = 0;
      for (int r = 0; r <= NT; r++) begin
         for (int i = 0; i <= NT; i++) begin
            int e;
            ref_w = mk(r, i);
            in_w  = mk(i, r + 3);
            wait_valid(H + SH + 2, got);
            if (got) begin
               if (jcal % CE == 0) refm = r - NT / 2;
               e = refm - (i - NT / 2);
               chk(int'(err_o) == e, (jcal % CE == 0) ? "R8 calibrated error" : "R9 reused reference",
                   int'(err_o), e);
               check_hold(e);
            end
            jcal++;
         end
      end

      finish_run();
   end

endmodule